// File: doc/BRIEF.md
# Paged Descriptor Ring Index Manager

This block keeps the index state of three circular descriptor rings that a host shares with a device: a request ring the device consumes, a completion ring it fills and a message ring it fills. Each ring lives in a handful of host memory pages that need not be adjacent. For every ring the block keeps a page number table, a wrap mask and a free-running local pointer. It turns that pointer into the byte address of the next descriptor slot.

Software-facing logic loads the page tables and starts ring setup. The device datapath pops slots and asks for the indices to be published. The block writes the shared index fields through a single write port, one field per cycle. It holds completion and message producer updates back until the descriptor writes of that batch have drained. It also reports whether the request ring is empty and whether the message ring can take another entry.

Top module: `ring_index_mgr`

## Requirements
- R1: After reset or a one-cycle `cleanup_i` pulse, all pointers, wrap masks and page table entries are zero, both setup-done states are cleared and pending publications are dropped. No shared write follows, `cmp_addr_o` reads 0, `msg_room_o` is 0, and with `req_prod_i` = 0 `req_empty_o` is 1 and `req_addr_o` is 0.
- R2: A ring of P pages holds P·E entries, with E = 32 (request), 128 (completion) or 64 (message). Its exponent k is the bit length of P·E − 1, with a minimum of 1. Its wrap mask is 2^k − 1.
- R3: A slot address is the page number from table entry (slot / E) shifted left by 12, plus (slot mod E) times the descriptor size: 128 bytes (request), 32 (completion) or 64 (message). Here slot = pointer AND mask.
- R4: The request ring is empty when `req_prod_i` equals the local consumed pointer. When empty, `req_addr_o` is 0 and `req_pop_i` leaves the pointer unchanged. Otherwise `req_addr_o` is the slot address of the consumed pointer, and a pop advances the pointer by one at the clock edge.
- R5: A `req_flush_i` pulse publishes the consumed pointer, as held at the start of that cycle, to field 1 (request consumer). This is a single write in the next cycle when nothing of higher priority is pending.
- R6: A `cmp_pop_i` always advances the completion pointer, with no overflow check. `cmp_addr_o` wraps through the mask.
- R7: `msg_room_o` is 1 only when the message ring has been set up and (`msg_prod_i` − `msg_cons_i`) mod 2^32 < mask + 1.
- R8: A completion publication (field 3, filled pointer) or a message publication (field 6, filled pointer) is never written while `desc_busy_i` is high. It is written in the first cycle in which `desc_busy_i` is low and no higher-priority write is due.
- R9: A `setup_data_i` pulse zeroes the request and completion pointers and sets their masks. It drops their pending publications. In the six following cycles it writes fields 0,1,2,3,4,5 with the data 0, 0, k_req, 0, 0, k_cmp.
- R10: A `setup_msg_i` pulse takes effect only after a data setup. It then zeroes the message pointer and sets its mask. In the three following cycles it writes fields 6,7,8 with the data 0, 0, k_msg. Before any data setup, the pulse causes no write and `msg_room_o` stays 0.
- R11: Only one shared write happens per cycle. Priority runs from the setup sequence, to the request consumer, to the completion producer, to the message producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cleanup_i | input | 1 | Synchronous clear of all ring state |
| pg_we_i | input | 1 | Page table entry write strobe |
| pg_ring_i | input | 2 | Ring select for the entry write (0 request, 1 completion, 2 message) |
| pg_idx_i | input | 3 | Table entry index |
| pg_ppn_i | input | 20 | Page number to store |
| setup_data_i | input | 1 | Start request and completion ring setup |
| req_npages_i | input | 4 | Request ring page count |
| cmp_npages_i | input | 4 | Completion ring page count |
| setup_msg_i | input | 1 | Start message ring setup |
| msg_npages_i | input | 4 | Message ring page count |
| req_prod_i | input | 32 | Shared request producer index |
| req_pop_i | input | 1 | Consume one request slot |
| req_empty_o | output | 1 | Request ring has nothing new |
| req_addr_o | output | 32 | Address of the next request slot, 0 when empty |
| req_flush_i | input | 1 | Publish the request consumer index |
| cmp_pop_i | input | 1 | Take one completion slot |
| cmp_addr_o | output | 32 | Address of the next completion slot |
| cmp_flush_i | input | 1 | Publish the completion producer index |
| msg_prod_i | input | 32 | Shared message producer index |
| msg_cons_i | input | 32 | Shared message consumer index |
| msg_room_o | output | 1 | Message ring can take an entry |
| msg_pop_i | input | 1 | Take one message slot |
| msg_addr_o | output | 32 | Address of the next message slot |
| msg_flush_i | input | 1 | Publish the message producer index |
| desc_busy_i | input | 1 | Descriptor writes still in flight |
| shm_we_o | output | 1 | Shared index field write strobe |
| shm_field_o | output | 4 | Field code 0..8 of the write |
| shm_data_o | output | 32 | Value written |

## Verification
The slot addresses, `req_empty_o` and `msg_room_o` are combinational on the current pointers and inputs, so the bench reads them in the same cycle as the stimulus. A pop moves the address one clock edge later. A flush or setup pulse shows up on the write port one cycle after the pulse, and a setup keeps writing on each following cycle. A held-back publication appears in the very cycle `desc_busy_i` falls. The bench drives every input just after a falling edge and samples one time step later. It moves to the next cycle exactly where these latencies put each result, and it checks the write port is idle in the cycle after each expected sequence.

// File: rtl/ring_idx_pkg.sv
package ring_idx_pkg;
  localparam int PTR_W    = 32;
  localparam int LOG_W    = 6;
  localparam int PG_SHIFT = 12;
  localparam int N_RINGS  = 3;
  localparam int RING_REQ = 0;
  localparam int RING_CMP = 1;
  localparam int RING_MSG = 2;

  // Shared index field codes; the setup sequencer walks them in order.
  typedef enum logic [3:0] {
    F_REQ_PROD = 4'd0, F_REQ_CONS = 4'd1, F_REQ_LOG2 = 4'd2,
    F_CMP_PROD = 4'd3, F_CMP_CONS = 4'd4, F_CMP_LOG2 = 4'd5,
    F_MSG_PROD = 4'd6, F_MSG_CONS = 4'd7, F_MSG_LOG2 = 4'd8,
    F_NONE     = 4'd15
  } shm_field_e;

  // Position of the highest set bit plus one, never below one.
  function automatic logic [LOG_W-1:0] bit_len(input logic [PTR_W-1:0] v);
    logic [LOG_W-1:0] n;
    n = LOG_W'(1);
    for (int i = 1; i < PTR_W; i++)
      if (v[i]) n = LOG_W'(i + 1);
    return n;
  endfunction

  function automatic logic [PTR_W-1:0] low_mask(input logic [LOG_W-1:0] k);
    return PTR_W'((64'd1 << k) - 64'd1);
  endfunction
endpackage

// File: rtl/ring_lane.sv
module ring_lane
  import ring_idx_pkg::*;
#(
  parameter int EPP       = 32,
  parameter int DESC      = 128,
  parameter int PPN_W     = 20,
  parameter int MAX_PAGES = 8,
  localparam int NPG_W    = $clog2(MAX_PAGES + 1),
  localparam int PGI_W    = $clog2(MAX_PAGES),
  localparam int ADDR_W   = PPN_W + PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              init_i,
  input  logic [NPG_W-1:0]  npages_i,
  input  logic              pg_we_i,
  input  logic [PGI_W-1:0]  pg_idx_i,
  input  logic [PPN_W-1:0]  ppn_i,
  input  logic              adv_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [LOG_W-1:0]  log2_o,
  output logic [ADDR_W-1:0] slot_addr_o
);
  logic [PPN_W-1:0] ptab [MAX_PAGES];
  logic [PTR_W-1:0] ptr, mask, slot;
  logic [LOG_W-1:0] lg, k_new;
  logic [PGI_W-1:0] pg;

  assign k_new = bit_len(PTR_W'(npages_i) * PTR_W'(EPP) - PTR_W'(1));
  assign slot  = ptr & mask;
  assign pg    = PGI_W'(slot / PTR_W'(EPP));
  assign slot_addr_o = {ptab[pg], {PG_SHIFT{1'b0}}}
                     + ADDR_W'((slot % PTR_W'(EPP)) * PTR_W'(DESC));
  assign ptr_o  = ptr;
  assign log2_o = lg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      mask <= '0;
      lg   <= '0;
      for (int i = 0; i < MAX_PAGES; i++) ptab[i] <= '0;
    end else if (clr_i) begin
      ptr  <= '0;
      mask <= '0;
      lg   <= '0;
      for (int i = 0; i < MAX_PAGES; i++) ptab[i] <= '0;
    end else begin
      if (pg_we_i) ptab[pg_idx_i] <= ppn_i;
      if (init_i) begin
        ptr  <= '0;
        lg   <= k_new;
        mask <= low_mask(k_new);
      end else if (adv_i) begin
        ptr <= ptr + PTR_W'(1);
      end
    end
  end
endmodule

// File: rtl/shm_publisher.sv
module shm_publisher
  import ring_idx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             seq_data_i,
  input  logic             seq_msg_i,
  input  logic             req_flush_i,
  input  logic             cmp_flush_i,
  input  logic             msg_flush_i,
  input  logic [PTR_W-1:0] req_ptr_i,
  input  logic [PTR_W-1:0] cmp_ptr_i,
  input  logic [PTR_W-1:0] msg_ptr_i,
  input  logic [LOG_W-1:0] req_log2_i,
  input  logic [LOG_W-1:0] cmp_log2_i,
  input  logic [LOG_W-1:0] msg_log2_i,
  input  logic             desc_busy_i,
  output logic             shm_we_o,
  output shm_field_e       shm_field_o,
  output logic [PTR_W-1:0] shm_data_o
);
  logic             seq_on;
  logic [3:0]       step, step_end;
  logic             req_pend, cmp_pend, msg_pend;
  logic [PTR_W-1:0] req_val, cmp_val, msg_val;
  logic             gnt_req, gnt_cmp, gnt_msg;

  always_comb begin
    shm_we_o    = 1'b0;
    shm_field_o = F_NONE;
    shm_data_o  = '0;
    gnt_req = 1'b0;
    gnt_cmp = 1'b0;
    gnt_msg = 1'b0;
    if (seq_on) begin
      shm_we_o    = 1'b1;
      shm_field_o = shm_field_e'(step);
      if (step == 4'(F_REQ_LOG2))      shm_data_o = PTR_W'(req_log2_i);
      else if (step == 4'(F_CMP_LOG2)) shm_data_o = PTR_W'(cmp_log2_i);
      else if (step == 4'(F_MSG_LOG2)) shm_data_o = PTR_W'(msg_log2_i);
    end else if (req_pend) begin
      shm_we_o = 1'b1; shm_field_o = F_REQ_CONS; shm_data_o = req_val; gnt_req = 1'b1;
    end else if (cmp_pend && !desc_busy_i) begin
      shm_we_o = 1'b1; shm_field_o = F_CMP_PROD; shm_data_o = cmp_val; gnt_cmp = 1'b1;
    end else if (msg_pend && !desc_busy_i) begin
      shm_we_o = 1'b1; shm_field_o = F_MSG_PROD; shm_data_o = msg_val; gnt_msg = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_on <= 1'b0; step <= '0; step_end <= '0;
      req_pend <= 1'b0; cmp_pend <= 1'b0; msg_pend <= 1'b0;
      req_val <= '0; cmp_val <= '0; msg_val <= '0;
    end else if (clr_i) begin
      seq_on <= 1'b0; step <= '0; step_end <= '0;
      req_pend <= 1'b0; cmp_pend <= 1'b0; msg_pend <= 1'b0;
      req_val <= '0; cmp_val <= '0; msg_val <= '0;
    end else begin
      if (seq_on) begin
        if (step == step_end) seq_on <= 1'b0;
        else                  step   <= step + 4'd1;
      end
      if (seq_data_i) begin
        seq_on <= 1'b1; step <= 4'(F_REQ_PROD); step_end <= 4'(F_CMP_LOG2);
      end else if (seq_msg_i) begin
        seq_on <= 1'b1; step <= 4'(F_MSG_PROD); step_end <= 4'(F_MSG_LOG2);
      end
      if (gnt_req) req_pend <= 1'b0;
      if (gnt_cmp) cmp_pend <= 1'b0;
      if (gnt_msg) msg_pend <= 1'b0;
      if (req_flush_i) begin req_pend <= 1'b1; req_val <= req_ptr_i; end
      if (cmp_flush_i) begin cmp_pend <= 1'b1; cmp_val <= cmp_ptr_i; end
      if (msg_flush_i) begin msg_pend <= 1'b1; msg_val <= msg_ptr_i; end
      if (seq_data_i) begin req_pend <= 1'b0; cmp_pend <= 1'b0; end
      if (seq_msg_i)  msg_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_index_mgr.sv
module ring_index_mgr
  import ring_idx_pkg::*;
#(
  parameter int PPN_W     = 20,
  parameter int MAX_PAGES = 8,
  parameter int REQ_SLOTS = 32,
  parameter int CMP_SLOTS = 128,
  parameter int MSG_SLOTS = 64,
  parameter int REQ_DESC  = 128,
  parameter int CMP_DESC  = 32,
  parameter int MSG_DESC  = 64,
  localparam int NPG_W    = $clog2(MAX_PAGES + 1),
  localparam int PGI_W    = $clog2(MAX_PAGES),
  localparam int ADDR_W   = PPN_W + PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cleanup_i,
  input  logic              pg_we_i,
  input  logic [1:0]        pg_ring_i,
  input  logic [PGI_W-1:0]  pg_idx_i,
  input  logic [PPN_W-1:0]  pg_ppn_i,
  input  logic              setup_data_i,
  input  logic [NPG_W-1:0]  req_npages_i,
  input  logic [NPG_W-1:0]  cmp_npages_i,
  input  logic              setup_msg_i,
  input  logic [NPG_W-1:0]  msg_npages_i,
  input  logic [PTR_W-1:0]  req_prod_i,
  input  logic              req_pop_i,
  output logic              req_empty_o,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              req_flush_i,
  input  logic              cmp_pop_i,
  output logic [ADDR_W-1:0] cmp_addr_o,
  input  logic              cmp_flush_i,
  input  logic [PTR_W-1:0]  msg_prod_i,
  input  logic [PTR_W-1:0]  msg_cons_i,
  output logic              msg_room_o,
  input  logic              msg_pop_i,
  output logic [ADDR_W-1:0] msg_addr_o,
  input  logic              msg_flush_i,
  input  logic              desc_busy_i,
  output logic              shm_we_o,
  output logic [3:0]        shm_field_o,
  output logic [PTR_W-1:0]  shm_data_o
);
  logic [PTR_W-1:0]  ptr_w  [N_RINGS];
  logic [LOG_W-1:0]  lg_w   [N_RINGS];
  logic [ADDR_W-1:0] addr_w [N_RINGS];
  logic [NPG_W-1:0]  npg_w  [N_RINGS];
  logic [N_RINGS-1:0] init_w, adv_w;
  logic data_ok, msg_ok, msg_init;
  logic [PTR_W-1:0] msg_fill;
  shm_field_e field_w;

  assign msg_init = setup_msg_i && data_ok;
  assign init_w   = {msg_init, setup_data_i, setup_data_i};
  assign adv_w    = {msg_pop_i, cmp_pop_i, req_pop_i && !req_empty_o};
  assign npg_w[RING_REQ] = req_npages_i;
  assign npg_w[RING_CMP] = cmp_npages_i;
  assign npg_w[RING_MSG] = msg_npages_i;

  for (genvar g = 0; g < N_RINGS; g++) begin : g_ring
    localparam int EPP = (g == RING_REQ) ? REQ_SLOTS : (g == RING_CMP) ? CMP_SLOTS : MSG_SLOTS;
    localparam int DSZ = (g == RING_REQ) ? REQ_DESC  : (g == RING_CMP) ? CMP_DESC  : MSG_DESC;
    ring_lane #(.EPP(EPP), .DESC(DSZ), .PPN_W(PPN_W), .MAX_PAGES(MAX_PAGES)) u_lane (
      .clk(clk), .rst_n(rst_n), .clr_i(cleanup_i), .init_i(init_w[g]),
      .npages_i(npg_w[g]), .pg_we_i(pg_we_i && (pg_ring_i == 2'(g))),
      .pg_idx_i(pg_idx_i), .ppn_i(pg_ppn_i), .adv_i(adv_w[g]),
      .ptr_o(ptr_w[g]), .log2_o(lg_w[g]), .slot_addr_o(addr_w[g])
    );
  end

  assign req_empty_o = (req_prod_i == ptr_w[RING_REQ]);
  assign req_addr_o  = req_empty_o ? '0 : addr_w[RING_REQ];
  assign cmp_addr_o  = addr_w[RING_CMP];
  assign msg_addr_o  = addr_w[RING_MSG];

  assign msg_fill   = msg_prod_i - msg_cons_i;
  assign msg_room_o = msg_ok &&
    ({1'b0, msg_fill} < ({1'b0, low_mask(lg_w[RING_MSG])} + 33'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_ok <= 1'b0;
      msg_ok  <= 1'b0;
    end else if (cleanup_i) begin
      data_ok <= 1'b0;
      msg_ok  <= 1'b0;
    end else begin
      if (setup_data_i) data_ok <= 1'b1;
      if (msg_init)     msg_ok  <= 1'b1;
    end
  end

  shm_publisher u_pub (
    .clk(clk), .rst_n(rst_n), .clr_i(cleanup_i),
    .seq_data_i(setup_data_i), .seq_msg_i(msg_init),
    .req_flush_i(req_flush_i), .cmp_flush_i(cmp_flush_i), .msg_flush_i(msg_flush_i),
    .req_ptr_i(ptr_w[RING_REQ]), .cmp_ptr_i(ptr_w[RING_CMP]), .msg_ptr_i(ptr_w[RING_MSG]),
    .req_log2_i(lg_w[RING_REQ]), .cmp_log2_i(lg_w[RING_CMP]), .msg_log2_i(lg_w[RING_MSG]),
    .desc_busy_i(desc_busy_i),
    .shm_we_o(shm_we_o), .shm_field_o(field_w), .shm_data_o(shm_data_o)
  );
  assign shm_field_o = 4'(field_w);
endmodule

// File: rtl/ring_index_chk.sv
module ring_index_chk
  import ring_idx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cleanup_i,
  input logic             setup_data_i,
  input logic             setup_msg_i,
  input logic             req_pop_i,
  input logic             req_empty_o,
  input logic [PTR_W-1:0] req_ptr,
  input logic             cmp_pop_i,
  input logic [PTR_W-1:0] cmp_ptr,
  input logic             desc_busy_i,
  input logic             shm_we_o,
  input logic [3:0]       shm_field_o,
  input logic             seq_on,
  input logic             msg_room_o,
  input logic             msg_ok
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pop_i && req_empty_o && !cleanup_i && !setup_data_i |=> req_ptr == $past(req_ptr));
  // R4
  req_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pop_i && !req_empty_o && !cleanup_i && !setup_data_i |=> req_ptr == $past(req_ptr) + 32'd1);
  // R6
  cmp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pop_i && !cleanup_i && !setup_data_i |=> cmp_ptr == $past(cmp_ptr) + 32'd1);
  // R8
  publish_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shm_we_o && !seq_on && (shm_field_o == 4'd3 || shm_field_o == 4'd6) |-> !desc_busy_i);
  // R1
  cleanup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cleanup_i |=> !shm_we_o && req_ptr == '0 && cmp_ptr == '0 && !msg_room_o);
  // R7
  room_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_room_o |-> msg_ok);
  // R9
  setup_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shm_we_o && seq_on && shm_field_o == 4'd0 && !cleanup_i && !setup_data_i && !setup_msg_i
    |=> shm_we_o && shm_field_o == 4'd1);
endmodule

bind ring_index_mgr ring_index_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cleanup_i(cleanup_i),
  .setup_data_i(setup_data_i), .setup_msg_i(setup_msg_i),
  .req_pop_i(req_pop_i), .req_empty_o(req_empty_o), .req_ptr(ptr_w[0]),
  .cmp_pop_i(cmp_pop_i), .cmp_ptr(ptr_w[1]), .desc_busy_i(desc_busy_i),
  .shm_we_o(shm_we_o), .shm_field_o(shm_field_o), .seq_on(u_pub.seq_on),
  .msg_room_o(msg_room_o), .msg_ok(msg_ok)
);

// File: tb/tb_ring_index_mgr.sv
module tb_ring_index_mgr;
  logic clk = 1'b0, rst_n = 1'b0, cleanup_i = 1'b0;
  logic pg_we_i = 1'b0;
  logic [1:0] pg_ring_i = '0;
  logic [2:0] pg_idx_i = '0;
  logic [19:0] pg_ppn_i = '0;
  logic setup_data_i = 1'b0, setup_msg_i = 1'b0;
  logic [3:0] req_npages_i = '0, cmp_npages_i = '0, msg_npages_i = '0;
  logic [31:0] req_prod_i = '0, msg_prod_i = '0, msg_cons_i = '0;
  logic req_pop_i = 1'b0, req_flush_i = 1'b0, cmp_pop_i = 1'b0, cmp_flush_i = 1'b0;
  logic msg_pop_i = 1'b0, msg_flush_i = 1'b0, desc_busy_i = 1'b0;
  logic req_empty_o, msg_room_o, shm_we_o;
  logic [31:0] req_addr_o, cmp_addr_o, msg_addr_o, shm_data_o;
  logic [3:0] shm_field_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [19:0] tppn [3][8];
  int unsigned epp [3] = '{32, 128, 64};
  int unsigned dsz [3] = '{128, 32, 64};
  logic [31:0] eptr [3];
  logic [31:0] emask [3];

  ring_index_mgr dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic exp_wr(input string tag, input int fld, input logic [31:0] d);
    chk({tag, " we"}, 64'(shm_we_o), 64'd1);
    chk({tag, " field"}, 64'(shm_field_o), 64'(fld));
    chk({tag, " data"}, 64'(shm_data_o), 64'(d));
  endtask

  function automatic int klen(input int r, input int n);
    logic [31:0] v;
    int k;
    v = 32'(n) * epp[r] - 32'd1;
    k = 0;
    while (v != 0) begin v = v >> 1; k++; end
    if (k == 0) k = 1;
    return k;
  endfunction

  function automatic logic [31:0] exp_addr(input int r, input logic [31:0] p);
    logic [31:0] slot, pg;
    slot = p & emask[r];
    pg = slot / epp[r];
    return {tppn[r][pg[2:0]], 12'h000} + (slot % epp[r]) * dsz[r];
  endfunction

  task automatic load(input int r, input int n);
    for (int p = 0; p < n; p++) begin
      nxt();
      pg_we_i = 1'b1; pg_ring_i = 2'(r); pg_idx_i = 3'(p);
      pg_ppn_i = 20'($urandom);
      tppn[r][p] = pg_ppn_i;
    end
    nxt();
    pg_we_i = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    int kq, kc, km, n;
    seed = $urandom(32'd4242);
    for (int r = 0; r < 3; r++) begin
      eptr[r] = '0; emask[r] = '0;
      for (int p = 0; p < 8; p++) tppn[r][p] = '0;
    end
    repeat (3) nxt();
    rst_n = 1'b1;
    settle();
    // R1 reset state
    chk("R1 reset we", 64'(shm_we_o), 64'd0);
    chk("R1 reset cmp addr", 64'(cmp_addr_o), 64'd0);
    chk("R1 reset room", 64'(msg_room_o), 64'd0);
    chk("R1 reset empty", 64'(req_empty_o), 64'd1);
    chk("R1 reset req addr", 64'(req_addr_o), 64'd0);

    load(0, 3); load(1, 2); load(2, 2);

    // R10 message setup before data setup is ignored
    nxt(); setup_msg_i = 1'b1; msg_npages_i = 4'd2;
    nxt(); setup_msg_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      settle();
      chk("R10 early msg setup no write", 64'(shm_we_o), 64'd0);
      chk("R10 early msg room", 64'(msg_room_o), 64'd0);
      nxt();
    end

    // R9 / R2 data setup sequence
    kq = klen(0, 3); kc = klen(1, 2); km = klen(2, 2);
    setup_data_i = 1'b1; req_npages_i = 4'd3; cmp_npages_i = 4'd2;
    nxt(); setup_data_i = 1'b0;
    emask[0] = 32'((64'd1 << kq) - 1); emask[1] = 32'((64'd1 << kc) - 1);
    settle(); exp_wr("R9 w0", 0, 0);
    nxt(); settle(); exp_wr("R9 w1", 1, 0);
    nxt(); settle(); exp_wr("R2 R9 w2 req log2", 2, 32'(kq));
    nxt(); settle(); exp_wr("R9 w3", 3, 0);
    nxt(); settle(); exp_wr("R9 w4", 4, 0);
    nxt(); settle(); exp_wr("R2 R9 w5 cmp log2", 5, 32'(kc));
    nxt(); settle(); chk("R9 sequence ends", 64'(shm_we_o), 64'd0);

    // R10 message setup
    setup_msg_i = 1'b1;
    nxt(); setup_msg_i = 1'b0;
    emask[2] = 32'((64'd1 << km) - 1);
    settle(); exp_wr("R10 w6", 6, 0);
    nxt(); settle(); exp_wr("R10 w7", 7, 0);
    nxt(); settle(); exp_wr("R2 R10 w8 msg log2", 8, 32'(km));
    chk("R7 room after setup", 64'(msg_room_o), 64'd1);
    nxt(); settle(); chk("R10 sequence ends", 64'(shm_we_o), 64'd0);

    // R4 / R3 request pops
    req_prod_i = 32'd5;
    for (int i = 0; i < 5; i++) begin
      req_pop_i = 1'b1; settle();
      chk("R4 not empty", 64'(req_empty_o), 64'd0);
      chk("R3 R4 req addr", 64'(req_addr_o), 64'(exp_addr(0, eptr[0])));
      eptr[0]++;
      nxt();
    end
    settle();
    chk("R4 empty", 64'(req_empty_o), 64'd1);
    chk("R4 empty addr zero", 64'(req_addr_o), 64'd0);
    nxt(); req_pop_i = 1'b0; req_prod_i = 32'd6; settle();
    chk("R4 pop on empty ignored", 64'(req_addr_o), 64'(exp_addr(0, 32'd5)));
    while (eptr[0] < 32'd220) begin
      n = $urandom_range(1, 12);
      req_prod_i = eptr[0] + 32'(n);
      for (int i = 0; i < n; i++) begin
        req_pop_i = 1'b1; settle();
        chk("R3 R4 req addr wrap", 64'(req_addr_o), 64'(exp_addr(0, eptr[0])));
        eptr[0]++;
        nxt();
      end
      req_pop_i = 1'b0;
    end
    settle();
    chk("R4 batch drained", 64'(req_empty_o), 64'd1);

    // R5 consumer publication
    nxt(); req_flush_i = 1'b1;
    nxt(); req_flush_i = 1'b0; settle();
    exp_wr("R5 consumer write", 1, eptr[0]);
    nxt(); settle(); chk("R5 single write", 64'(shm_we_o), 64'd0);

    // R6 completion pops wrap without check
    for (int i = 0; i < 300; i++) begin
      cmp_pop_i = 1'b1; settle();
      chk("R3 R6 cmp addr", 64'(cmp_addr_o), 64'(exp_addr(1, eptr[1])));
      eptr[1]++;
      nxt();
    end
    cmp_pop_i = 1'b0;

    // R8 deferred completion publication
    desc_busy_i = 1'b1; cmp_flush_i = 1'b1;
    nxt(); cmp_flush_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      settle(); chk("R8 held while busy", 64'(shm_we_o), 64'd0);
      nxt();
    end
    desc_busy_i = 1'b0; settle();
    exp_wr("R8 released", 3, eptr[1]);
    nxt(); settle(); chk("R8 single write", 64'(shm_we_o), 64'd0);

    // R3 message pops
    for (int i = 0; i < 10; i++) begin
      msg_pop_i = 1'b1; settle();
      chk("R3 msg addr", 64'(msg_addr_o), 64'(exp_addr(2, eptr[2])));
      eptr[2]++;
      nxt();
    end
    msg_pop_i = 1'b0;

    // R11 priority of publications
    req_flush_i = 1'b1; cmp_flush_i = 1'b1; msg_flush_i = 1'b1;
    nxt(); req_flush_i = 1'b0; cmp_flush_i = 1'b0; msg_flush_i = 1'b0; settle();
    exp_wr("R11 first req", 1, eptr[0]);
    nxt(); settle(); exp_wr("R11 second cmp", 3, eptr[1]);
    nxt(); settle(); exp_wr("R11 third msg", 6, eptr[2]);
    nxt(); settle(); chk("R11 idle", 64'(shm_we_o), 64'd0);

    // R7 message room, directed and random
    msg_cons_i = 32'd1000; msg_prod_i = 32'd1127; settle();
    chk("R7 room one left", 64'(msg_room_o), 64'd1);
    msg_prod_i = 32'd1128; settle();
    chk("R7 full", 64'(msg_room_o), 64'd0);
    msg_cons_i = 32'hFFFF_FFF0; msg_prod_i = 32'h0000_0010; settle();
    chk("R7 modulo wrap", 64'(msg_room_o), 64'd1);
    msg_prod_i = 32'hFFFF_FFEF; settle();
    chk("R7 negative diff", 64'(msg_room_o), 64'd0);
    for (int i = 0; i < 20; i++) begin
      n = $urandom_range(0, 200);
      msg_cons_i = $urandom; msg_prod_i = msg_cons_i + 32'(n); settle();
      chk("R7 random room", 64'(msg_room_o), 64'(n < 128));
    end
    msg_cons_i = '0; msg_prod_i = '0;

    // R9 re-setup zeroes pointers
    nxt(); setup_data_i = 1'b1;
    nxt(); setup_data_i = 1'b0;
    eptr[0] = '0; eptr[1] = '0;
    repeat (6) nxt();
    req_prod_i = 32'd1; settle();
    chk("R9 cmp pointer zeroed", 64'(cmp_addr_o), 64'(exp_addr(1, 32'd0)));
    chk("R9 req pointer zeroed", 64'(req_addr_o), 64'(exp_addr(0, 32'd0)));

    // R1 cleanup drops pending publication and clears state
    nxt(); req_prod_i = '0; desc_busy_i = 1'b1; cmp_flush_i = 1'b1;
    nxt(); cmp_flush_i = 1'b0; cleanup_i = 1'b1;
    nxt(); cleanup_i = 1'b0; desc_busy_i = 1'b0; settle();
    for (int r = 0; r < 3; r++) begin
      eptr[r] = '0; emask[r] = '0;
      for (int p = 0; p < 8; p++) tppn[r][p] = '0;
    end
    chk("R1 cleanup no write", 64'(shm_we_o), 64'd0);
    chk("R1 cleanup cmp addr", 64'(cmp_addr_o), 64'd0);
    chk("R1 cleanup room", 64'(msg_room_o), 64'd0);
    chk("R1 cleanup empty", 64'(req_empty_o), 64'd1);
    nxt(); settle();
    chk("R1 cleanup still idle", 64'(shm_we_o), 64'd0);

    // R2 smaller geometry after cleanup
    load(0, 1); load(1, 1);
    setup_data_i = 1'b1; req_npages_i = 4'd1; cmp_npages_i = 4'd1;
    nxt(); setup_data_i = 1'b0;
    kq = klen(0, 1); kc = klen(1, 1);
    emask[0] = 32'((64'd1 << kq) - 1); emask[1] = 32'((64'd1 << kc) - 1);
    nxt(); nxt(); settle(); exp_wr("R2 one-page req log2", 2, 32'(kq));
    nxt(); nxt(); nxt(); settle(); exp_wr("R2 one-page cmp log2", 5, 32'(kc));
    nxt();
    for (int i = 0; i < 140; i++) begin
      cmp_pop_i = 1'b1; settle();
      chk("R2 R6 one-page cmp wrap", 64'(cmp_addr_o), 64'(exp_addr(1, eptr[1])));
      eptr[1]++;
      nxt();
    end
    cmp_pop_i = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule